// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The controller gathers eight external interrupt request lines and presents a single request signal to a processor. Each line has a fixed priority equal to its index, so line 7 is the most urgent. Per line, the controller can be set to sense either the level or the rising edge of the input, and each line can be enabled or blocked. While a handler runs, the controller masks its level and every lower level. A more urgent line can still interrupt that handler, so handlers can nest. Line 7 is non-maskable.

The processor acknowledges with a one-cycle strobe. In that same cycle the controller presents the source number and a vector, which is a programmable base plus the source number. At that point the chosen line moves into service. An end-of-service pulse retires the most recent (highest) level in service, which restores the mask that was in force before it. The controller has two arbitration models, selected by a configuration bit. One is a static priority encoder. The other gives the request to the most recently triggered line.

A four-entry register port sets the trigger modes, the enables, the vector base and the arbitration model. Inputs are assumed to be synchronous to the clock.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous reset, the following hold: `int_req` is 0, all lines are level-sensitive, all enables are 0, the vector base is 0, static arbitration is selected and no level is in service. A raised line 0 then produces no request.
- R2: A line whose bit at configuration address 0 is 0 is level-sensitive. It requests while its input is high. `int_req` follows a change on the input two clock edges later. If the line is still high when its level leaves service, it requests again.
- R3: A line whose bit at address 0 is 1 is edge-sensitive. A rising edge makes it pending, and it stays pending after the input returns low, until it is acknowledged. A rising edge in the acknowledge cycle leaves the line pending. Several rising edges before the acknowledge count as one request.
- R4: Bit i at address 1 enables line i (1 permits, 0 blocks) for lines 0 to 6.
- R5: With static arbitration (address 3 bit 0 = 0), the eligible line with the highest index is chosen.
- R6: With latest-request arbitration (address 3 bit 0 = 1), the line that most recently became pending is chosen if it is still eligible. An eligible line 7 always wins. Otherwise the choice falls back to static priority.
- R7: An acknowledge while `int_req` is 1 has these effects. In that cycle, `ack_num` gives the chosen line and `ack_vec` gives the vector. The line's edge request is cleared and its level enters service. `int_req` is 0 on the following cycle.
- R8: While any level L is in service, lines at L and below do not request. A line above every level in service requests, and it can be acknowledged on top of the levels in service (nesting).
- R9: An `eoi` pulse removes the highest level in service only, which restores the mask of the level beneath it.
- R10: Line 7 requests regardless of its enable bit and of the levels in service.
- R11: An acknowledge while `int_req` is 0 changes no state.
- R12: When an acknowledge and `eoi` fall in the same cycle, the level that was highest in service beforehand is retired and the newly acknowledged level enters service.
- R13: Address 2 holds the vector base. `ack_vec` = (base + source number) modulo 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | External request lines, bit i = line i |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| int_req | output | 1 | Request to the processor |
| int_ack | input | 1 | Acknowledge strobe from the processor |
| ack_num | output | 3 | Chosen source number, valid with the acknowledge |
| ack_vec | output | 8 | Vector number, valid with the acknowledge |
| eoi | input | 1 | End-of-service pulse |

## Verification
Acknowledge and end-of-service can land in the same cycle, and they act on the same in-service record from opposite sides. The bench puts line 2 in service, raises line 6 so that it nests, and then pulses acknowledge and end-of-service together. It then drops line 6 and raises line 4. No request may appear, because only line 6 should be left in service, and line 6 masks line 4. After a further end-of-service, the acknowledge must return line 4.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    CFG_TRIG   = 2'd0,
    CFG_ENABLE = 2'd1,
    CFG_VBASE  = 2'd2,
    CFG_ARB    = 2'd3
  } cfg_sel_e;

  typedef enum logic {
    ARB_STATIC = 1'b0,
    ARB_LATEST = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/irqc_cfg_regs.sv
module irqc_cfg_regs
  import irqc_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int VEC_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [N_SRC-1:0]  edge_mode,
  output logic [N_SRC-1:0]  enable,
  output logic [VEC_W-1:0]  vbase,
  output arb_mode_e         arb
);
  always_ff @(posedge clk) begin
    if (rst) begin
      edge_mode <= '0;
      enable    <= '0;
      vbase     <= '0;
      arb       <= ARB_STATIC;
    end else if (we) begin
      case (cfg_sel_e'(addr))
        CFG_TRIG:   edge_mode <= wdata[N_SRC-1:0];
        CFG_ENABLE: enable    <= wdata[N_SRC-1:0];
        CFG_VBASE:  vbase     <= wdata[VEC_W-1:0];
        CFG_ARB:    arb       <= arb_mode_e'(wdata[0]);
      endcase
    end
  end
endmodule

// File: rtl/irqc_req_latch.sv
module irqc_req_latch #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_in,
  input  logic [N_SRC-1:0] edge_mode,
  input  logic [N_SRC-1:0] clr_oh,
  output logic [N_SRC-1:0] pending,
  output logic [N_SRC-1:0] fresh
);
  logic [N_SRC-1:0] irq_q;
  logic [N_SRC-1:0] edge_pend;
  logic [N_SRC-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q     <= '0;
      edge_pend <= '0;
      pend_q    <= '0;
    end else begin
      irq_q  <= irq_in;
      pend_q <= pending;
      for (int i = 0; i < N_SRC; i++) begin
        if (!edge_mode[i])                edge_pend[i] <= 1'b0;
        else if (irq_in[i] && !irq_q[i])  edge_pend[i] <= 1'b1;
        else if (clr_oh[i])               edge_pend[i] <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign pending[g] = edge_mode[g] ? edge_pend[g] : irq_q[g];
  end

  assign fresh = pending & ~pend_q;

  // R3
  edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (|edge_pend) |=> (((edge_pend | ~edge_mode) & $past(edge_pend & edge_mode & ~clr_oh))
                      == $past(edge_pend & edge_mode & ~clr_oh)));
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
#(
  parameter  int N_SRC = 8,
  localparam int SW    = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] pending,
  input  logic [N_SRC-1:0] fresh,
  input  logic [N_SRC-1:0] enable,
  input  logic [N_SRC-1:0] isr,
  input  arb_mode_e        arb,
  input  logic             ack_fire,
  output logic             int_req_q,
  output logic [SW-1:0]    sel_q
);
  localparam logic [SW-1:0] TOP = SW'(N_SRC - 1);

  logic [N_SRC-1:0] elig;
  logic [SW-1:0]    stat_idx, fresh_idx, last_q, cand, win;

  for (genvar g = 0; g < N_SRC; g++) begin : g_elig
    if (g == N_SRC - 1) begin : g_nmi
      assign elig[g] = pending[g];
    end else begin : g_norm
      assign elig[g] = pending[g] & enable[g] & ~(|isr[N_SRC-1:g]);
    end
  end

  always_comb begin
    stat_idx  = '0;
    fresh_idx = '0;
    for (int k = 0; k < N_SRC; k++) begin
      if (elig[k])  stat_idx  = SW'(k);
      if (fresh[k]) fresh_idx = SW'(k);
    end
    cand = (|fresh) ? fresh_idx : last_q;
    if (elig[TOP])                              win = TOP;
    else if (arb == ARB_LATEST && elig[cand])   win = cand;
    else                                        win = stat_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_req_q <= 1'b0;
      sel_q     <= '0;
      last_q    <= '0;
    end else begin
      int_req_q <= (|elig) && !ack_fire;
      sel_q     <= win;
      if (|fresh) last_q <= fresh_idx;
    end
  end

  // R4
  enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (int_req_q && sel_q != TOP && $stable(enable)) |-> enable[sel_q]);
endmodule

// File: rtl/irqc_service.sv
module irqc_service #(
  parameter  int N_SRC = 8,
  localparam int SW    = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             int_ack,
  input  logic             int_req,
  input  logic             eoi,
  input  logic [SW-1:0]    sel,
  output logic             ack_fire,
  output logic [N_SRC-1:0] ack_oh,
  output logic [N_SRC-1:0] isr
);
  localparam logic [N_SRC-1:0] ONE = N_SRC'(1);
  localparam logic [SW-1:0]    TOP = SW'(N_SRC - 1);

  logic [N_SRC-1:0] top_oh;

  assign ack_fire = int_ack & int_req;
  assign ack_oh   = ack_fire ? (ONE << sel) : '0;

  always_comb begin
    top_oh = '0;
    for (int k = 0; k < N_SRC; k++)
      if (isr[k]) top_oh = ONE << k;
  end

  always_ff @(posedge clk) begin
    if (rst) isr <= '0;
    else     isr <= (isr & ~(eoi ? top_oh : '0)) | ack_oh;
  end

  // R8
  nest_order_chk: assert property (@(posedge clk) disable iff (rst)
    ack_fire |-> (sel == TOP || (isr >> sel) == '0));

  // R9
  eoi_single_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi && !ack_fire && isr != '0) |=> ($countones(isr) == $countones($past(isr)) - 1));

  // R11
  stray_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (int_ack && !int_req && !eoi) |=> $stable(isr));

  // R12
  ack_eoi_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_fire && eoi) |=> isr[$past(sel)]);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter  int N_SRC  = 8,
  parameter  int VEC_W  = 8,
  parameter  int DATA_W = 8,
  localparam int SW     = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  irq_in,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              int_req,
  input  logic              int_ack,
  output logic [SW-1:0]     ack_num,
  output logic [VEC_W-1:0]  ack_vec,
  input  logic              eoi
);
  logic [N_SRC-1:0] edge_mode, enable, pending, fresh, isr, ack_oh;
  logic [VEC_W-1:0] vbase;
  arb_mode_e        arb;
  logic             ack_fire;
  logic [SW-1:0]    sel_q;

  irqc_cfg_regs #(.N_SRC(N_SRC), .VEC_W(VEC_W), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .edge_mode(edge_mode), .enable(enable), .vbase(vbase), .arb(arb));

  irqc_req_latch #(.N_SRC(N_SRC)) u_latch (
    .clk(clk), .rst(rst), .irq_in(irq_in), .edge_mode(edge_mode),
    .clr_oh(ack_oh), .pending(pending), .fresh(fresh));

  irqc_arbiter #(.N_SRC(N_SRC)) u_arb (
    .clk(clk), .rst(rst), .pending(pending), .fresh(fresh), .enable(enable),
    .isr(isr), .arb(arb), .ack_fire(ack_fire), .int_req_q(int_req), .sel_q(sel_q));

  irqc_service #(.N_SRC(N_SRC)) u_svc (
    .clk(clk), .rst(rst), .int_ack(int_ack), .int_req(int_req), .eoi(eoi),
    .sel(sel_q), .ack_fire(ack_fire), .ack_oh(ack_oh), .isr(isr));

  assign ack_num = sel_q;
  assign ack_vec = vbase + VEC_W'(sel_q);

  // R7
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (int_ack && int_req) |=> !int_req);
endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       int_req;
  logic       int_ack = 1'b0;
  logic [2:0] ack_num;
  logic [7:0] ack_vec;
  logic       eoi = 1'b0;

  int         checks = 0;
  int         fails = 0;
  logic [7:0] base = '0;
  bit         done = 1'b0;

  // {enable[7:0], lines[7:0], expect_req, expect_num[2:0]}; level mode, static
  localparam int NV = 8;
  localparam logic [19:0] VTAB [NV] = '{
    20'hFF04A, 20'hFFA1F, 20'h7F26D, 20'h007F0,
    20'h0F700, 20'h0F80F, 20'h0A0EB, 20'hFF018
  };

  always #2 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .int_req(int_req), .int_ack(int_ack), .ack_num(ack_num),
    .ack_vec(ack_vec), .eoi(eoi));

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(logic [1:0] a, logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_eoi();
    eoi = 1'b1;
    step(1);
    eoi = 1'b0;
  endtask

  task automatic ack_check(logic [2:0] exp_num, string tag);
    int_ack = 1'b1;
    chk({tag, " R7 ack_num"}, ack_num, exp_num);
    chk({tag, " R13 ack_vec"}, ack_vec, 8'(base + exp_num));
    step(1);
    int_ack = 1'b0;
    chk({tag, " R7 int_req after ack"}, int_req, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(4);
    rst = 1'b0;
    step(1);
    // R1 reset state
    chk("R1 int_req", int_req, 0);
    chk("R1 ack_num", ack_num, 0);
    chk("R1 ack_vec", ack_vec, 0);
    irq_in = 8'h01; step(3);
    chk("R1 enables clear", int_req, 0);
    irq_in = 8'h00; step(2);

    cfg_write(2'd2, 8'h40); base = 8'h40;

    // table: R4 R5 R10
    for (int v = 0; v < NV; v++) begin
      cfg_write(2'd1, VTAB[v][19:12]);
      irq_in = VTAB[v][11:4];
      step(2);
      chk("R4 R5 R10 table int_req", int_req, VTAB[v][3]);
      if (VTAB[v][3]) begin
        ack_check(VTAB[v][2:0], "R5 table");
        irq_in = 8'h00;
        pulse_eoi();
      end else begin
        irq_in = 8'h00;
      end
      step(2);
    end

    cfg_write(2'd1, 8'hFF);
    // R2 level follows input, re-requests after service
    irq_in = 8'h08; step(2);
    chk("R2 level request", int_req, 1);
    irq_in = 8'h00; step(2);
    chk("R2 level dropped", int_req, 0);
    irq_in = 8'h08; step(2);
    ack_check(3'd3, "R2");
    step(1);
    chk("R8 own level masked", int_req, 0);
    pulse_eoi(); step(1);
    chk("R2 re-request while high", int_req, 1);
    ack_check(3'd3, "R2 second");
    irq_in = 8'h00; pulse_eoi(); step(2);

    // R3 edge latch and collapse
    cfg_write(2'd0, 8'h10);
    irq_in = 8'h10; step(1); irq_in = 8'h00; step(1);
    irq_in = 8'h10; step(1); irq_in = 8'h00; step(2);
    chk("R3 edge held after line idle", int_req, 1);
    ack_check(3'd4, "R3");
    pulse_eoi(); step(3);
    chk("R3 two edges one request", int_req, 0);
    cfg_write(2'd0, 8'h00);

    // R8 nesting, R9 end of service
    irq_in = 8'h04; step(2);
    ack_check(3'd2, "R8 base");
    irq_in = 8'h06; step(2);
    chk("R8 lower masked", int_req, 0);
    irq_in = 8'h26; step(2);
    chk("R8 higher nests", int_req, 1);
    ack_check(3'd5, "R8 nested");
    irq_in = 8'h06; step(1);
    pulse_eoi(); step(2);
    chk("R9 level 2 still masks", int_req, 0);
    pulse_eoi(); step(2);
    chk("R9 mask released", int_req, 1);
    ack_check(3'd2, "R9");
    irq_in = 8'h00; pulse_eoi(); step(2);

    // R12 acknowledge and end of service together
    irq_in = 8'h04; step(2);
    ack_check(3'd2, "R12 base");
    irq_in = 8'h44; step(2);
    chk("R12 nested request", int_req, 1);
    int_ack = 1'b1; eoi = 1'b1;
    chk("R12 ack_num", ack_num, 6);
    step(1);
    int_ack = 1'b0; eoi = 1'b0;
    irq_in = 8'h14; step(2);
    chk("R12 only level 6 in service", int_req, 0);
    pulse_eoi(); step(2);
    chk("R12 released", int_req, 1);
    ack_check(3'd4, "R12");
    irq_in = 8'h00; pulse_eoi(); step(2);

    // R6 latest-request arbitration
    cfg_write(2'd3, 8'h01);
    cfg_write(2'd0, 8'hFF);
    irq_in = 8'h20; step(1); irq_in = 8'h00; step(1);
    irq_in = 8'h04; step(1); irq_in = 8'h00; step(2);
    chk("R6 request", int_req, 1);
    ack_check(3'd2, "R6 latest wins");
    step(1);
    chk("R6 fallback request", int_req, 1);
    ack_check(3'd5, "R6 fallback");
    pulse_eoi(); pulse_eoi(); step(2);
    irq_in = 8'h80; step(1); irq_in = 8'h00; step(1);
    irq_in = 8'h02; step(1); irq_in = 8'h00; step(2);
    ack_check(3'd7, "R6 R10 line 7 beats latest");
    pulse_eoi(); step(2);
    chk("R6 line 1 after release", int_req, 1);
    ack_check(3'd1, "R6 line 1");
    pulse_eoi();
    cfg_write(2'd3, 8'h00);
    cfg_write(2'd0, 8'h00);
    step(2);

    // R11 stray acknowledge
    chk("R11 idle", int_req, 0);
    int_ack = 1'b1; step(1); int_ack = 1'b0;
    irq_in = 8'h01; step(2);
    chk("R11 line 0 not masked", int_req, 1);
    ack_check(3'd0, "R11");
    irq_in = 8'h00; pulse_eoi(); step(2);

    // R13 vector base wrap
    cfg_write(2'd2, 8'hFE); base = 8'hFE;
    irq_in = 8'h20; step(2);
    ack_check(3'd5, "R13 wrap");
    irq_in = 8'h00; pulse_eoi(); step(2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule